// File: doc/BRIEF.md
# Dual-Clock Sample FIFO with Full Held Through Reset

This block moves fixed-width converter samples from a sample-clock domain into an independent network-side clock domain. The producer pushes at most one sample per write clock and is never stalled while space remains. The consumer pulls samples out in bursts, typically one burst per outgoing frame. It uses the read-side fill level to decide when a burst is worth starting.

Each side keeps a binary pointer one bit wider than the storage address, together with a Gray-coded copy. Each Gray copy crosses to the other domain through a chain of synchronizer flops. Full is decided in the write domain and empty in the read domain, each against the other side's synchronized pointer. The read port is first-word-fall-through: the oldest stored sample is shown on the data output whenever empty is low.

A build option makes full read high while the write-side reset is asserted and for two write clocks after its release. Writes arriving in that window are refused. With the option off, full depends only on the pointers.

Top module: `smp_xfifo`

## Requirements
- R1: While both resets are asserted: `rd_empty` is 1, `rd_level` is 0, `wr_ovf` is 0 and `rd_udf` is 0.
- R2: With `FULL_AT_RESET`=1, `wr_full` is 1 while `wr_rst_n` is 0. It stays 1 after the first rising `wr_clk` edge following release and drops to 0 after the second edge, provided the FIFO is not genuinely full.
- R3: With `FULL_AT_RESET`=0, `wr_full` is 0 during reset.
- R4: Samples leave in the order they were written. `rd_data` shows the oldest sample whenever `rd_empty` is 0, and a read (`rd_en`=1 while not empty, taken at the `rd_clk` edge) advances to the next one.
- R5: `wr_full` rises right after the `wr_clk` edge that stores the 2^`ADDR_W`-th unread sample. It is 0 while fewer are stored and all reads have been synchronized.
- R6: A write attempted while `wr_full` is 1 stores nothing and sets `wr_ovf`, which then stays 1 until write reset.
- R7: A read attempted while `rd_empty` is 1 moves no pointer and sets `rd_udf`, which then stays 1 until read reset.
- R8: Once the synchronizers have settled, `rd_level` equals the number of unread samples. It never exceeds 2^`ADDR_W`.
- R9: `rd_empty` stays 1 for at least the synchronizer delay after a write. It rises in the read cycle that removes the last sample, and it is 1 exactly when `rd_level` is 0.
- R10: A writer pushing one sample on every write clock, drained in bursts by a faster reader, loses no sample and never sets `wr_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Sample to push |
| wr_full | output | 1 | No space, or reset hold active |
| wr_ovf | output | 1 | Sticky: a push was refused |
| rd_clk | input | 1 | Network-side clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Oldest unread sample |
| rd_empty | output | 1 | Nothing to read |
| rd_level | output | ADDR_W+1 | Unread samples as seen by the read side |
| rd_udf | output | 1 | Sticky: a pop was refused |

## Verification
The bench builds the main instance with 12-bit data, `ADDR_W`=3 (eight entries) and two synchronizer stages. The small depth lets full, wrap-around of the extra pointer bit and the refused write be reached within a few dozen writes. A second instance with `FULL_AT_RESET`=0 is built beside it, so both reset variants of full are observed in the same run. The write clock is slower than and unrelated to the read clock, which lets the streaming scenario keep a steady push rate while the reader starts and ends bursts on the fill level.

// File: rtl/smp_xfifo_pkg.sv
`timescale 1ns/1ps
package smp_xfifo_pkg;
   // smallest legal address width: full compare inverts the top two pointer bits
   localparam int unsigned MIN_ADDR_W  = 2;
   // fewest flops allowed in a pointer crossing
   localparam int unsigned MIN_SYNC    = 2;
   // write clocks that full is held after write reset release
   localparam int unsigned HOLD_CYCLES = 2;
endpackage

// File: rtl/smp_xfifo_sync.sv
`timescale 1ns/1ps
module smp_xfifo_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/smp_xfifo_ram.sv
`timescale 1ns/1ps
module smp_xfifo_ram #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/smp_xfifo_wctl.sv
`timescale 1ns/1ps
module smp_xfifo_wctl #(
   parameter int unsigned ADDR_W        = 4,
   parameter bit          FULL_AT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W:0]   rgray_sync,
   output logic [ADDR_W-1:0] waddr,
   output logic              we,
   output logic [ADDR_W:0]   wgray,
   output logic              full,
   output logic              ovf
);
   localparam int unsigned PW = ADDR_W + 1;

   logic [PW-1:0] wbin_q, wbin_nxt, wgray_q;
   logic          full_ptr, hold, ovf_q;

   // full when the far pointer is exactly one lap behind
   assign full_ptr = (wgray_q == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});

   if (FULL_AT_RESET) begin : g_hold
      logic [smp_xfifo_pkg::HOLD_CYCLES-1:0] rel_sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rel_sr <= '0;
         else        rel_sr <= {rel_sr[smp_xfifo_pkg::HOLD_CYCLES-2:0], 1'b1};
      end
      assign hold = ~rel_sr[smp_xfifo_pkg::HOLD_CYCLES-1];
   end else begin : g_nohold
      assign hold = 1'b0;
   end

   assign full     = full_ptr | hold;
   assign we       = wr_en & ~full;
   assign wbin_nxt = wbin_q + PW'(we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         wbin_q  <= wbin_nxt;
         wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
         if (wr_en && full) ovf_q <= 1'b1;
      end
   end

   assign waddr = wbin_q[ADDR_W-1:0];
   assign wgray = wgray_q;
   assign ovf   = ovf_q;
endmodule

// File: rtl/smp_xfifo_rctl.sv
`timescale 1ns/1ps
module smp_xfifo_rctl #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wgray_sync,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic              empty,
   output logic [ADDR_W:0]   level,
   output logic              udf
);
   localparam int unsigned PW = ADDR_W + 1;

   logic [PW-1:0] rbin_q, rbin_nxt, rgray_q, wbin_s;
   logic          re, udf_q;

   // Gray to binary: each bit is the parity of itself and all bits above
   for (genvar i = 0; i < int'(PW); i++) begin : g_g2b
      assign wbin_s[i] = ^wgray_sync[PW-1:i];
   end

   assign empty    = (rgray_q == wgray_sync);
   assign re       = rd_en & ~empty;
   assign rbin_nxt = rbin_q + PW'(re);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         udf_q   <= 1'b0;
      end else begin
         rbin_q  <= rbin_nxt;
         rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
         if (rd_en && empty) udf_q <= 1'b1;
      end
   end

   assign raddr = rbin_q[ADDR_W-1:0];
   assign rgray = rgray_q;
   assign level = wbin_s - rbin_q;
   assign udf   = udf_q;
endmodule

// File: rtl/smp_xfifo.sv
`timescale 1ns/1ps
module smp_xfifo #(
   parameter int unsigned DATA_W        = 12,
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          FULL_AT_RESET = 1'b1
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   output logic              wr_ovf,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic [ADDR_W:0]   rd_level,
   output logic              rd_udf
);
   localparam int unsigned PW = ADDR_W + 1;

   if (ADDR_W < smp_xfifo_pkg::MIN_ADDR_W) begin : g_bad_addr_w
      $error("smp_xfifo: ADDR_W must be at least 2");
   end
   if (SYNC_STAGES < smp_xfifo_pkg::MIN_SYNC) begin : g_bad_sync
      $error("smp_xfifo: SYNC_STAGES must be at least 2");
   end

   logic [ADDR_W-1:0] waddr, raddr;
   logic              we;
   logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;

   smp_xfifo_wctl #(.ADDR_W(ADDR_W), .FULL_AT_RESET(FULL_AT_RESET)) u_wctl (
      .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
      .waddr(waddr), .we(we), .wgray(wgray), .full(wr_full), .ovf(wr_ovf)
   );

   smp_xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_ws)
   );

   smp_xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rs)
   );

   smp_xfifo_rctl #(.ADDR_W(ADDR_W)) u_rctl (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_sync(wgray_rs),
      .raddr(raddr), .rgray(rgray), .empty(rd_empty), .level(rd_level), .udf(rd_udf)
   );

   smp_xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(rd_data)
   );
endmodule

// File: rtl/smp_xfifo_chk.sv
`timescale 1ns/1ps
module smp_xfifo_chk #(
   parameter int unsigned ADDR_W        = 4,
   parameter bit          FULL_AT_RESET = 1'b1
) (
   input logic            wr_clk,
   input logic            wr_rst_n,
   input logic            wr_en,
   input logic            wr_full,
   input logic            wr_ovf,
   input logic            rd_clk,
   input logic            rd_rst_n,
   input logic            rd_en,
   input logic            rd_empty,
   input logic [ADDR_W:0] rd_level,
   input logic            rd_udf
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   // R6
   ovf_set_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && wr_full) |=> wr_ovf);
   // R6
   ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_ovf |=> wr_ovf);
   // R7
   udf_set_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && rd_empty) |=> rd_udf);
   // R7
   udf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_udf |=> rd_udf);
   // R8
   level_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_level <= (ADDR_W+1)'(DEPTH));
   // R9
   empty_level_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_empty == (rd_level == '0));

   if (FULL_AT_RESET) begin : g_hold_chk
      // R2
      full_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
         $rose(wr_rst_n) |-> wr_full);
   end
endmodule

bind smp_xfifo smp_xfifo_chk #(.ADDR_W(ADDR_W), .FULL_AT_RESET(FULL_AT_RESET)) u_chk (
   .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
   .wr_ovf(wr_ovf), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
   .rd_empty(rd_empty), .rd_level(rd_level), .rd_udf(rd_udf)
);

// File: tb/smp_xfifo_tb_top.sv
`timescale 1ns/1ps
module smp_xfifo_tb_top;
   localparam int DW = 12;
   localparam int AW = 3;
   localparam int DEPTH = 1 << AW;

   logic wclk = 1'b0, rclk = 1'b0;
   logic wrst_n = 1'b0, rrst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_full, wr_ovf, rd_empty, rd_udf;
   logic [DW-1:0] rd_data;
   logic [AW:0] rd_level;
   logic nh_full, nh_ovf, nh_empty, nh_udf;
   logic [DW-1:0] nh_data;
   logic [AW:0] nh_level;

   int checks = 0, fails = 0;
   bit wdone = 1'b0;

   always #5 wclk = ~wclk;   // write side, 100 MHz
   always #2 rclk = ~rclk;   // read side, 250 MHz

   smp_xfifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .FULL_AT_RESET(1'b1)) dut_i (
      .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .wr_ovf(wr_ovf), .rd_clk(rclk), .rd_rst_n(rrst_n),
      .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .rd_level(rd_level),
      .rd_udf(rd_udf)
   );

   smp_xfifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .FULL_AT_RESET(1'b0)) dut_nohold_i (
      .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en(1'b0), .wr_data('0),
      .wr_full(nh_full), .wr_ovf(nh_ovf), .rd_clk(rclk), .rd_rst_n(rrst_n),
      .rd_en(1'b0), .rd_data(nh_data), .rd_empty(nh_empty), .rd_level(nh_level),
      .rd_udf(nh_udf)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge rclk);
      repeat (4) @(posedge wclk);
      @(negedge rclk);
   endtask

   task automatic pop_expect(input int n, input int base, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge rclk);
         chk(req, int'(rd_data), base + i);
         rd_en = 1'b1;
      end
      @(negedge rclk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      wr_en = 1'b0; rd_en = 1'b0;
      wrst_n = 1'b0; rrst_n = 1'b0;
      repeat (3) @(posedge wclk);
      #1;
      chk("R2 full in reset", int'(wr_full), 1);
      chk("R3 full in reset, no hold", int'(nh_full), 0);
      chk("R1 empty", int'(rd_empty), 1);
      chk("R1 level", int'(rd_level), 0);
      chk("R1 ovf", int'(wr_ovf), 0);
      chk("R1 udf", int'(rd_udf), 0);
      @(negedge rclk) rrst_n = 1'b1;
      @(negedge wclk) wrst_n = 1'b1;
      @(posedge wclk); #1;
      chk("R2 full after 1st edge", int'(wr_full), 1);
      @(posedge wclk); #1;
      chk("R2 full after 2nd edge", int'(wr_full), 0);
      chk("R3 full after release, no hold", int'(nh_full), 0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 5; i++) begin
         @(negedge wclk);
         wr_en = 1'b1; wr_data = DW'(12'h100 + i);
         if (i == 0) begin
            @(posedge wclk); #1;
            chk("R9 empty held during sync", int'(rd_empty), 1);
         end
      end
      @(negedge wclk) wr_en = 1'b0;
      settle();
      chk("R8 level after 5 writes", int'(rd_level), 5);
      chk("R9 not empty", int'(rd_empty), 0);
      pop_expect(5, 12'h100, "R4 order");
      chk("R9 empty after drain", int'(rd_empty), 1);
      chk("R9 level after drain", int'(rd_level), 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge wclk);
         if (i == DEPTH - 1) chk("R5 not full one short", int'(wr_full), 0);
         wr_en = 1'b1; wr_data = DW'(12'h200 + i);
      end
      @(negedge wclk);
      chk("R5 full at depth", int'(wr_full), 1);
      wr_data = 12'hEEE;              // wr_en still 1: refused push
      @(negedge wclk) wr_en = 1'b0;
      chk("R6 ovf set", int'(wr_ovf), 1);
      chk("R6 still full", int'(wr_full), 1);
      settle();
      chk("R8 level at depth", int'(rd_level), DEPTH);
      pop_expect(DEPTH, 12'h200, "R6 refused write not stored");
      chk("R9 empty after full drain", int'(rd_empty), 1);
      chk("R6 ovf sticky", int'(wr_ovf), 1);
   endtask

   task automatic t_underflow();
      @(negedge rclk);
      chk("R7 udf clear before", int'(rd_udf), 0);
      rd_en = 1'b1;
      @(negedge rclk) rd_en = 1'b0;
      chk("R7 udf set", int'(rd_udf), 1);
      chk("R7 level unchanged", int'(rd_level), 0);
      @(negedge wclk) begin wr_en = 1'b1; wr_data = 12'h3A5; end
      @(negedge wclk) wr_en = 1'b0;
      settle();
      chk("R7 level after one write", int'(rd_level), 1);
      pop_expect(1, 12'h3A5, "R7 read pointer unmoved");
      chk("R7 udf sticky", int'(rd_udf), 1);
   endtask

   task automatic t_stream();
      t_reset();
      wdone = 1'b0;
      fork
         begin
            for (int i = 0; i < 64; i++) begin
               @(negedge wclk);
               wr_en = 1'b1; wr_data = DW'(12'h400 + i);
            end
            @(negedge wclk) wr_en = 1'b0;
            wdone = 1'b1;
         end
         begin
            int got = 0;
            bit bursting = 1'b0;
            while (got < 64) begin
               @(negedge rclk);
               rd_en = 1'b0;
               if (!rd_empty && (bursting || rd_level >= 4 || wdone)) begin
                  chk("R10 stream data", int'(rd_data), 12'h400 + got);
                  got++;
                  rd_en = 1'b1;
                  bursting = 1'b1;
               end else begin
                  bursting = 1'b0;
               end
            end
            @(negedge rclk) rd_en = 1'b0;
         end
      join
      settle();
      chk("R10 no overflow", int'(wr_ovf), 0);
      chk("R10 empty at end", int'(rd_empty), 1);
   endtask

   initial begin
      t_reset();
      t_order();
      t_full();
      t_underflow();
      t_stream();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule